// File: doc/BRIEF.md
# Reset Status and Boot-Configuration Capture

This block sits next to a reset controller and gives software one status word and one control word about reset. The status word records whether the last reset the controller accepted came from a software system request. It also holds two sticky flags, one for a software external reset and one for a glitch seen on the reset pin, and the weak-pull and boot-configuration values captured when the outgoing reset was released.

The control word takes one-shot software requests for a system reset or an external reset. Each request appears as a single-cycle pulse toward the reset controller. The boot field is filled by a conditional capture when the outgoing reset is released. If the configuration-enable pin is high, the boot pins are taken as they are. Otherwise the field is derived from the low halfword of a security control word.

Every register access finishes in the cycle it is presented. Reads are combinational on `reg_sel`.

Top module: `reset_status_unit`

## Requirements
- R1: A write to the control word (`reg_sel`=1) with `reg_wdata[1]`=1 raises `sw_ext_req` for exactly the next cycle. The control word always reads as 0.
- R2: A write to the control word with `reg_wdata[0]`=1 raises `sw_sys_req` for exactly the next cycle. This is the software system reset request.
- R3: On a cycle with `ack_valid` high, status bit 17 takes the value of `ack_sw_sys`. When `ack_valid` is low the bit holds.
- R4: Status bit 16, the software external reset flag, becomes 1 on the clock edge at which `sw_ext_req` is high. Writing the status word with bit 16 set clears it.
- R5: Status bit 0, the glitch flag, becomes 1 after a cycle with `glitch_seen` high. Only a status write with bit 0 set, or power-on reset, clears it.
- R6: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R7: A release of the outgoing reset is defined as `rst_out` sampled 1 and then 0 on the next edge. At a release, status bit 15 captures `wkpull_pin`.
- R8: At a release with `cfg_en_pin`=1, status bits 2:1 capture `boot_pins`.
- R9: At a release with `cfg_en_pin`=0, status bits 2:1 become 2'b10 if `sec_word_lo` is all zeros or all ones. Otherwise they become 2'b00.
- R10: Bits 15 and 2:1 hold their captured values until the next release. Pin changes and software writes do not alter them.
- R11: Bits 31:18 and 14:3 of the status word read 0. Writes to read-only bits have no effect.
- R12: While `por_n` is low, every flag, captured field and request output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| ack_valid | input | 1 | Reset controller has acknowledged a reset source |
| ack_sw_sys | input | 1 | The acknowledged source was a software system reset |
| glitch_seen | input | 1 | Glitch-detected strobe from the reset pin filter |
| rst_out | input | 1 | Level of the outgoing reset, 1 = asserted |
| wkpull_pin | input | 1 | Weak-pull configuration pin |
| cfg_en_pin | input | 1 | Configuration-enable pin |
| boot_pins | input | 2 | Boot configuration pins |
| sec_word_lo | input | 16 | Low halfword of the security control word |
| sw_sys_req | output | 1 | One-cycle software system reset request |
| sw_ext_req | output | 1 | One-cycle software external reset request |

## Verification
A wrong internal state shows up on `reg_rdata` in the cycle after the edge that caused it, because the read path is combinational.

A request pulse that lasts too long, or a flag that misses its set, is visible two cycles after the write. A bad capture decision is visible right after the release edge. A capture at the wrong time, or a capture disturbed by a write, shows as a changed boot or weak-pull field while no release is taking place.

The bench sweeps every combination of configuration-enable, boot pins and weak-pull pin against several security halfwords. That covers both the all-zero and all-one cases and their near neighbours.

// File: rtl/reset_status_unit.sv
module reset_status_unit #(
  parameter int SEC_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ack_valid,
  input  logic             ack_sw_sys,
  input  logic             glitch_seen,
  input  logic             rst_out,
  input  logic             wkpull_pin,
  input  logic             cfg_en_pin,
  input  logic [1:0]       boot_pins,
  input  logic [SEC_W-1:0] sec_word_lo,
  output logic             sw_sys_req,
  output logic             sw_ext_req
);
  localparam int B_SSYS = 17;
  localparam int B_EXTF = 16;
  localparam int B_GLT  = 0;
  localparam int C_SYS  = 0;
  localparam int C_EXT  = 1;

  logic       ssys_q, extf_q, wkp_q, glitch_q, rst_out_q;
  logic [1:0] boot_q;

  wire wr_stat     = reg_wr && !reg_sel;
  wire wr_ctl      = reg_wr && reg_sel;
  wire rst_release = rst_out_q && !rst_out;
  wire sec_blank   = (sec_word_lo == '0) || (sec_word_lo == '1);
  wire [1:0] boot_nxt = cfg_en_pin ? boot_pins : (sec_blank ? 2'b10 : 2'b00);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sw_sys_req <= 1'b0;
      sw_ext_req <= 1'b0;
      rst_out_q  <= 1'b0;
    end else begin
      sw_sys_req <= wr_ctl && reg_wdata[C_SYS];
      sw_ext_req <= wr_ctl && reg_wdata[C_EXT];
      rst_out_q  <= rst_out;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         ssys_q <= 1'b0;
    else if (ack_valid) ssys_q <= ack_sw_sys;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          extf_q <= 1'b0;
    else if (sw_ext_req)                 extf_q <= 1'b1;
    else if (wr_stat && reg_wdata[B_EXTF]) extf_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                           glitch_q <= 1'b0;
    else if (glitch_seen)                 glitch_q <= 1'b1;
    else if (wr_stat && reg_wdata[B_GLT]) glitch_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wkp_q  <= 1'b0;
      boot_q <= 2'b00;
    end else if (rst_release) begin
      wkp_q  <= wkpull_pin;
      boot_q <= boot_nxt;
    end
  end

  assign reg_rdata = reg_sel ? 32'h0
                   : {14'h0, ssys_q, extf_q, wkp_q, 12'h0, boot_q, glitch_q};
endmodule

module reset_status_unit_chk (
  input logic        clk,
  input logic        por_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [31:0] reg_wdata,
  input logic        sw_sys_req,
  input logic        sw_ext_req,
  input logic        glitch_seen,
  input logic        rst_out,
  input logic        extf_q,
  input logic        glitch_q,
  input logic        wkp_q,
  input logic [1:0]  boot_q
);
  a_r1_ext_req_from_write: assert property (@(posedge clk) disable iff (!por_n)
    sw_ext_req |-> $past(reg_wr && reg_sel && reg_wdata[1]));

  a_r2_sys_req_from_write: assert property (@(posedge clk) disable iff (!por_n)
    sw_sys_req |-> $past(reg_wr && reg_sel && reg_wdata[0]));

  a_r4_ext_flag_sets: assert property (@(posedge clk) disable iff (!por_n)
    sw_ext_req |=> extf_q);

  a_r5_glitch_flag_sets: assert property (@(posedge clk) disable iff (!por_n)
    glitch_seen |=> glitch_q);

  a_r10_capture_holds: assert property (@(posedge clk) disable iff (!por_n)
    !($past(rst_out) && !rst_out) |=> $stable({boot_q, wkp_q}));
endmodule

bind reset_status_unit reset_status_unit_chk u_chk (
  .clk(clk), .por_n(por_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .sw_sys_req(sw_sys_req), .sw_ext_req(sw_ext_req),
  .glitch_seen(glitch_seen), .rst_out(rst_out), .extf_q(extf_q),
  .glitch_q(glitch_q), .wkp_q(wkp_q), .boot_q(boot_q)
);

// File: tb/reset_status_unit_bench.sv
module reset_status_unit_bench;
  logic clk = 0;
  logic por_n = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ack_valid = 0, ack_sw_sys = 0, glitch_seen = 0, rst_out = 0;
  logic wkpull_pin = 0, cfg_en_pin = 0;
  logic [1:0] boot_pins = 0;
  logic [15:0] sec_word_lo = 0;
  logic sw_sys_req, sw_ext_req;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reset_status_unit u_reset_status_unit (
    .clk(clk), .por_n(por_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_valid(ack_valid),
    .ack_sw_sys(ack_sw_sys), .glitch_seen(glitch_seen), .rst_out(rst_out),
    .wkpull_pin(wkpull_pin), .cfg_en_pin(cfg_en_pin), .boot_pins(boot_pins),
    .sec_word_lo(sec_word_lo), .sw_sys_req(sw_sys_req), .sw_ext_req(sw_ext_req)
  );

  logic e_ssys, e_extf, e_wkp, e_glt;
  logic [1:0] e_boot;

  function automatic logic [31:0] exp_status();
    logic [31:0] v = 32'h0;
    v[17] = e_ssys; v[16] = e_extf; v[15] = e_wkp;
    v[2:1] = e_boot; v[0] = e_glt;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic read_status(string req);
    reg_sel = 0; #1;
    check(req, reg_rdata, exp_status());
  endtask

  task automatic write_reg(logic sel, logic [31:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 0; reg_wdata = 0; reg_sel = 0;
  endtask

  task automatic release_reset(logic ce, logic [1:0] bp, logic wk, logic [15:0] sw);
    rst_out = 1; step();
    rst_out = 0; cfg_en_pin = ce; boot_pins = bp; wkpull_pin = wk; sec_word_lo = sw;
    step();
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] secs [6];
    secs[0] = 16'h0000; secs[1] = 16'hFFFF; secs[2] = 16'h0001;
    secs[3] = 16'hFFFE; secs[4] = 16'h8000; secs[5] = 16'h7FFF;
    {e_ssys, e_extf, e_wkp, e_glt} = 0; e_boot = 0;

    @(negedge clk); @(negedge clk);
    #1;
    check("R12 status in reset", reg_rdata, 32'h0);
    check("R12 requests in reset", {30'h0, sw_sys_req, sw_ext_req}, 32'h0);
    por_n = 1;
    step();
    read_status("R12 status after reset");

    // R2 system request pulse
    reg_wr = 1; reg_sel = 1; reg_wdata = 32'h1;
    step();
    reg_wr = 0; reg_wdata = 0;
    check("R2 sys req high", {30'h0, sw_sys_req, sw_ext_req}, 32'h2);
    step();
    check("R2 sys req one cycle", {30'h0, sw_sys_req, sw_ext_req}, 32'h0);
    read_status("R2 no flag from sys req");

    // R1 external request pulse and R4 flag timing
    reg_wr = 1; reg_sel = 1; reg_wdata = 32'h2;
    #1; check("R1 control reads zero", reg_rdata, 32'h0);
    step();
    reg_wr = 0; reg_wdata = 0; reg_sel = 0;
    check("R1 ext req high", {30'h0, sw_sys_req, sw_ext_req}, 32'h1);
    read_status("R4 flag not yet set");
    step();
    check("R1 ext req one cycle", {30'h0, sw_sys_req, sw_ext_req}, 32'h0);
    e_extf = 1; read_status("R4 flag set");
    write_reg(0, 32'h0001_0000);
    e_extf = 0; read_status("R4 flag cleared by write one");

    // R6 set wins for external flag
    write_reg(1, 32'h2);
    write_reg(0, 32'h0001_0000);
    e_extf = 1; read_status("R6 ext set beats clear");
    write_reg(0, 32'h0001_0000);
    e_extf = 0; read_status("R4 clear again");

    // R5 glitch flag
    glitch_seen = 1; step(); glitch_seen = 0;
    e_glt = 1; read_status("R5 glitch set");
    write_reg(0, 32'hFFFF_FFFE);
    read_status("R5 write without bit0 keeps flag");
    repeat (3) step();
    read_status("R5 flag sticky");
    glitch_seen = 1; write_reg(0, 32'h1); glitch_seen = 0;
    read_status("R6 glitch set beats clear");
    write_reg(0, 32'h1);
    e_glt = 0; read_status("R5 glitch cleared");

    // R3 acknowledged source
    ack_sw_sys = 1; step();
    read_status("R3 no ack no change");
    ack_valid = 1; step(); ack_valid = 0;
    e_ssys = 1; read_status("R3 sw sys acknowledged");
    ack_sw_sys = 0; step();
    read_status("R3 holds without ack");
    ack_valid = 1; step(); ack_valid = 0;
    e_ssys = 0; read_status("R3 other source acknowledged");
    ack_valid = 1; ack_sw_sys = 1; step(); ack_valid = 0; ack_sw_sys = 0;
    e_ssys = 1;

    // R7 R8 R9 sweep
    for (int ce = 0; ce < 2; ce++)
      for (int bp = 0; bp < 4; bp++)
        for (int wk = 0; wk < 2; wk++)
          for (int si = 0; si < 6; si++) begin
            release_reset(ce[0], bp[1:0], wk[0], secs[si]);
            e_wkp = wk[0];
            if (ce == 1) e_boot = bp[1:0];
            else e_boot = (secs[si] == 16'h0000 || secs[si] == 16'hFFFF) ? 2'b10 : 2'b00;
            read_status(ce == 1 ? "R8 pins captured" : "R9 security derived");
          end

    // R7 explicit capture value
    release_reset(1, 2'b01, 1, 16'h1234);
    e_wkp = 1; e_boot = 2'b01;
    read_status("R7 weak pull captured");

    // R10 hold against pins and writes
    rst_out = 0; cfg_en_pin = 0; boot_pins = 2'b10; wkpull_pin = 0; sec_word_lo = 16'h0;
    repeat (4) step();
    read_status("R10 pins change without release");
    write_reg(0, 32'h0000_8006);
    read_status("R10 write leaves capture");
    rst_out = 1; step();
    read_status("R10 assertion alone no capture");
    rst_out = 0; step();
    e_wkp = 0; e_boot = 2'b10;
    read_status("R10 next release captures");

    // R11 reserved bits and read-only writes
    write_reg(0, 32'hFFFE_7FFE);
    read_status("R11 reserved read zero after write");
    write_reg(1, 32'hFFFF_FFFC);
    check("R11 no request from other control bits", {30'h0, sw_sys_req, sw_ext_req}, 32'h0);
    read_status("R11 status unchanged by control write");

    // R12 power-on reset clears flags and captures
    glitch_seen = 1; step(); glitch_seen = 0;
    por_n = 0; #1;
    {e_ssys, e_extf, e_wkp, e_glt} = 0; e_boot = 0;
    read_status("R12 por clears all");
    step(); por_n = 1; step();
    read_status("R12 after por release");

    report();
  end
endmodule